// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register load or store request into a stream of single-word transfers. A request carries a base value, a 16-bit register mask and three mode bits: whether the word at the base is inside the transferred range, whether the range grows upward or downward from the base, and whether the base is to be written back. Once the request is accepted, the block emits one transfer per cycle. Each transfer carries a register index and a word address. The selected registers come out in ascending index order, and the lowest index always gets the lowest address.

When the last transfer has gone out, the block spends one cycle presenting the new base value and a write enable. The register file can then update the base register. An empty mask is flagged as an unpredictable request and produces no transfers at all. Bank selection, status restore and the data movement itself belong to the surrounding pipeline.

The controller has three states. `ST_IDLE` waits for `start`. A non-empty mask moves it to `ST_RUN` (transition *accept*). An empty mask keeps it in `ST_IDLE` and pulses the error flag (transition *reject*). `ST_RUN` emits one transfer per cycle and stays there until the transfer marked last (transition *walk*). After that transfer it moves to `ST_DONE` (transition *finish*). `ST_DONE` lasts one cycle and returns to `ST_IDLE` (transition *retire*). A synchronous reset forces `ST_IDLE` from any state.

Top module: `blkxfer_seq`

## Requirements
- R1: Bit i of `reg_mask` selects register i, for i from 0 to 15. While the block is running, each selected register appears on `xfer_idx` exactly once with `xfer_valid` high, in strictly ascending index order and one per cycle.
- R2: Each transfer after the first carries an address 4 higher than the previous one. This makes the addresses consecutive words running from the lowest selected register to the highest.
- R3: `xfer_addr` always has bits [1:0] equal to zero. Any low bits of `base_in` are cleared when the first address is formed.
- R4: Let N be the number of set mask bits. The first address, before alignment, depends on the two mode bits:
  - `incl_base`=1 and `up_dir`=1: the base.
  - `incl_base`=0 and `up_dir`=1: base+4.
  - `incl_base`=1 and `up_dir`=0: base−4N+4, so the base word is the top word of the range.
  - `incl_base`=0 and `up_dir`=0: base−4N, so the base word lies one word above the top of the range.
- R5: `xfer_last` is high on the final transfer of a request and on no other transfer.
- R6: `done` is high for exactly one cycle, in the cycle after the last transfer. In that cycle `wb_we` equals the latched `wb_req`. When `wb_we` is high, `wb_base` equals base+4N if `up_dir` was 1, or base−4N if it was 0, using the full unaligned base.
- R7: A start with an all-zero mask raises `bad_mask` for exactly the next cycle. It produces no `xfer_valid` and no `done`, and the block stays idle.
- R8: `start` is acted on only in `ST_IDLE`. A start raised while the block is running or in its done cycle changes no transfer, and it does not begin a new request.
- R9: With `rst` high at a clock edge, the block is in `ST_IDLE` after that edge, with `xfer_valid`, `done` and `bad_mask` low.
- R10: The first transfer of an accepted request appears in the cycle right after the edge that sampled `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, sampled only when idle |
| base_in | input | 32 | Base register value |
| reg_mask | input | 16 | One bit per register, bit i selects register i |
| incl_base | input | 1 | 1: the base word is inside the range; 0: it lies just outside |
| up_dir | input | 1 | 1: range above the base; 0: range below it |
| wb_req | input | 1 | Request write-back of the updated base |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_last | output | 1 | Final transfer of the request |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Word-aligned transfer address |
| done | output | 1 | One-cycle end-of-request pulse |
| wb_we | output | 1 | Write enable for the updated base |
| wb_base | output | 32 | Updated base value, valid while `done` is high |
| bad_mask | output | 1 | One-cycle pulse: an empty mask was rejected |

## Verification
The assertions treat the three controller states as visible at the ports: `xfer_valid` high means running, `done` high means the done cycle, and both low means idle. They also assume that `reset` is asserted from the first clock edge, so that no property sees pre-reset values. The stimulus holds reset through the opening edges. It raises `start` only with the block idle, except for deliberate pokes during a run and during the done cycle. It drops those pokes before the block returns to idle, so every new request starts from a known idle state.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
// Population count of a bit vector.
module blkxfer_popcnt #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/blkxfer_lowest.sv
// Finds the lowest set bit, its index, and the vector with that bit removed.
module blkxfer_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest,
    output logic          single
);
    logic [W:0]   seen;
    logic [W-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_chain
        assign first[g]  = vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign rest   = vec & ~first;
    assign single = seen[W] && (rest == '0);
endmodule

// File: rtl/blkxfer_span.sv
// Start address and final base for the four range placements.
module blkxfer_span #(
    parameter int AW = 32,
    parameter int CW = 5,
    parameter int SH = 2
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    input  logic          incl_base,
    input  logic          up_dir,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] end_base
);
    localparam logic [AW-1:0] STEP = AW'(1) << SH;

    logic [AW-1:0] span;
    assign span = AW'(cnt) << SH;

    always_comb begin
        if (up_dir) begin
            end_base   = base + span;
            first_addr = incl_base ? base : base + STEP;
        end else begin
            end_base   = base - span;
            first_addr = incl_base ? base - span + STEP : base - span;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [AW-1:0]             base_in,
    input  logic [NREG-1:0]           reg_mask,
    input  logic                      incl_base,
    input  logic                      up_dir,
    input  logic                      wb_req,
    output logic                      xfer_valid,
    output logic                      xfer_last,
    output logic [$clog2(NREG)-1:0]   xfer_idx,
    output logic [AW-1:0]             xfer_addr,
    output logic                      done,
    output logic                      wb_we,
    output logic [AW-1:0]             wb_base,
    output logic                      bad_mask
);
    import blkxfer_pkg::*;

    localparam int            IW    = $clog2(NREG);
    localparam int            CW    = $clog2(NREG + 1);
    localparam int            SH    = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP  = AW'(WORD_BYTES);
    localparam logic [AW-1:0] ALIGN = ~(STEP - AW'(1));

    seq_state_e state, state_nx;

    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   endb_q;
    logic            wb_q;
    logic            bad_q;

    logic [CW-1:0]   n_sel;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   end_base;
    logic [IW-1:0]   low_idx;
    logic [NREG-1:0] low_rest;
    logic            low_single;

    logic accept;
    logic reject;
    assign accept = (state == ST_IDLE) && start && (reg_mask != '0);
    assign reject = (state == ST_IDLE) && start && (reg_mask == '0);

    blkxfer_popcnt #(.W(NREG), .CW(CW)) u_cnt (
        .vec   (reg_mask),
        .count (n_sel)
    );

    blkxfer_span #(.AW(AW), .CW(CW), .SH(SH)) u_span (
        .base       (base_in),
        .cnt        (n_sel),
        .incl_base  (incl_base),
        .up_dir     (up_dir),
        .first_addr (first_addr),
        .end_base   (end_base)
    );

    blkxfer_lowest #(.W(NREG), .IW(IW)) u_low (
        .vec    (pend_q),
        .idx    (low_idx),
        .rest   (low_rest),
        .single (low_single)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)     state_nx = ST_RUN;
            ST_RUN:  if (low_single) state_nx = ST_DONE;
            ST_DONE:                 state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Request datapath.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            addr_q <= '0;
            endb_q <= '0;
            wb_q   <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            bad_q <= reject;
            if (accept) begin
                pend_q <= reg_mask;
                addr_q <= first_addr & ALIGN;
                endb_q <= end_base;
                wb_q   <= wb_req;
            end else if (state == ST_RUN) begin
                pend_q <= low_rest;
                addr_q <= addr_q + STEP;
            end
        end
    end

    // Outputs.
    always_comb begin
        xfer_valid = 1'b0;
        xfer_last  = 1'b0;
        xfer_idx   = '0;
        xfer_addr  = '0;
        done       = 1'b0;
        wb_we      = 1'b0;
        wb_base    = '0;
        unique case (state)
            ST_RUN: begin
                xfer_valid = 1'b1;
                xfer_last  = low_single;
                xfer_idx   = low_idx;
                xfer_addr  = addr_q;
            end
            ST_DONE: begin
                done    = 1'b1;
                wb_we   = wb_q;
                wb_base = endb_q;
            end
            default: ;
        endcase
    end
    assign bad_mask = bad_q;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [NREG-1:0]         reg_mask,
    input logic                    xfer_valid,
    input logic                    xfer_last,
    input logic [$clog2(NREG)-1:0] xfer_idx,
    input logic [AW-1:0]           xfer_addr,
    input logic                    done,
    input logic                    wb_we,
    input logic                    bad_mask
);
    localparam int LOWB = $clog2(WORD_BYTES);

    // R9: reset clears all activity.
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !xfer_valid && !done && !bad_mask);

    // R1, R2: each transfer after the first steps up by one word and a higher index.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_last |=> xfer_valid
            && (xfer_addr == $past(xfer_addr) + AW'(WORD_BYTES))
            && (xfer_idx > $past(xfer_idx)));

    // R3: aligned addresses.
    p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_addr[LOWB-1:0] == '0));

    // R5, R6: the last transfer is followed by a single done cycle.
    p_last_to_done_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_last |=> done && !xfer_valid);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !xfer_valid);

    p_wb_in_done_r6: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> done);

    // R7: an empty mask is rejected.
    p_empty_reject_r7: assert property (@(posedge clk) disable iff (rst)
        start && !xfer_valid && !done && (reg_mask == '0)
            |=> bad_mask && !xfer_valid && !done);

    p_bad_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        bad_mask |-> !xfer_valid && !done);

    // R10: an accepted start yields a transfer on the next cycle.
    p_first_xfer_r10: assert property (@(posedge clk) disable iff (rst)
        start && !xfer_valid && !done && (reg_mask != '0) |=> xfer_valid);

    // R8: no transfer can start straight out of the done cycle.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !xfer_valid);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(
    .AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .reg_mask   (reg_mask),
    .xfer_valid (xfer_valid),
    .xfer_last  (xfer_last),
    .xfer_idx   (xfer_idx),
    .xfer_addr  (xfer_addr),
    .done       (done),
    .wb_we      (wb_we),
    .bad_mask   (bad_mask)
);

// File: tb/blkxfer_seq_bench.sv
`timescale 1ns/1ps
module blkxfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_in = '0;
    logic [15:0] reg_mask = '0;
    logic        incl_base = 1'b0;
    logic        up_dir = 1'b0;
    logic        wb_req = 1'b0;
    logic        xfer_valid, xfer_last, done, wb_we, bad_mask;
    logic [3:0]  xfer_idx;
    logic [31:0] xfer_addr, wb_base;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    blkxfer_seq u_blkxfer_seq (
        .clk(clk), .rst(rst), .start(start), .base_in(base_in),
        .reg_mask(reg_mask), .incl_base(incl_base), .up_dir(up_dir),
        .wb_req(wb_req), .xfer_valid(xfer_valid), .xfer_last(xfer_last),
        .xfer_idx(xfer_idx), .xfer_addr(xfer_addr), .done(done),
        .wb_we(wb_we), .wb_base(wb_base), .bad_mask(bad_mask)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_one(input logic [31:0] b, input logic [15:0] m,
                           input bit p, input bit u, input bit w, input bit poke);
        int n = 0;
        int j = 0;
        logic [31:0] span, first, endb, ea;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        span = 32'(n) * 32'd4;
        if (u) begin
            first = p ? b : b + 32'd4;
            endb  = b + span;
        end else begin
            first = p ? b - span + 32'd4 : b - span;
            endb  = b - span;
        end
        base_in = b; reg_mask = m; incl_base = p; up_dir = u; wb_req = w;
        start = 1'b1;
        step();
        start = 1'b0;
        if (n == 0) begin
            chk(bad_mask == 1'b1, "R7 bad_mask", 32'(bad_mask), 32'd1);
            chk(xfer_valid == 1'b0, "R7 no transfer", 32'(xfer_valid), 32'd0);
            chk(done == 1'b0, "R7 no done", 32'(done), 32'd0);
            step();
            chk(bad_mask == 1'b0, "R7 single pulse", 32'(bad_mask), 32'd0);
            chk(xfer_valid == 1'b0, "R7 still idle", 32'(xfer_valid), 32'd0);
            return;
        end
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                ea = (first + 32'(j) * 32'd4) & ~32'd3;
                chk(xfer_valid == 1'b1, j == 0 ? "R10 first valid" : "R1 valid",
                    32'(xfer_valid), 32'd1);
                chk(xfer_idx == 4'(i), poke ? "R8 R1 index" : "R1 index",
                    32'(xfer_idx), 32'(i));
                chk(xfer_addr == ea, j == 0 ? "R4 R3 first address" : "R2 R3 address",
                    xfer_addr, ea);
                chk(xfer_last == (j == n - 1), "R5 last flag",
                    32'(xfer_last), 32'(j == n - 1));
                if (j == 0 && poke) begin
                    start = 1'b1; reg_mask = ~m; base_in = ~b;
                end
                step();
                start = 1'b0;
                j++;
            end
        end
        chk(done == 1'b1, "R6 done", 32'(done), 32'd1);
        chk(xfer_valid == 1'b0, "R6 no transfer in done", 32'(xfer_valid), 32'd0);
        chk(wb_we == w, "R6 wb_we", 32'(wb_we), 32'(w));
        if (w) chk(wb_base == endb, "R6 wb_base", wb_base, endb);
        if (poke) begin
            start = 1'b1; reg_mask = 16'h00F0;
        end
        step();
        chk(done == 1'b0 && xfer_valid == 1'b0, "R8 R6 back to idle",
            32'({done, xfer_valid}), 32'd0);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        logic [31:0] b;
        int k = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(xfer_valid == 1'b0 && done == 1'b0 && bad_mask == 1'b0,
            "R9 reset state", 32'({xfer_valid, done, bad_mask}), 32'd0);
        rst = 1'b0;
        step();

        // Single-bit masks in every mode.
        for (int s = 0; s < 16; s++) begin
            for (int md = 0; md < 8; md++) begin
                b = 32'h4000_0100 + 32'(s) * 32'h40 + 32'(md & 3);
                run_one(b, 16'(1) << s, md[0], md[1], md[2], (s % 5) == 0);
            end
        end
        // Fixed patterns and a pseudo-random set.
        lf = 16'hACE1;
        for (int t = 0; t < 40; t++) begin
            logic [15:0] m;
            case (t)
                0: m = 16'hFFFF;
                1: m = 16'h8001;
                2: m = 16'h5555;
                3: m = 16'hAAAA;
                4: m = 16'h0000;
                default: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    m = lf;
                end
            endcase
            for (int md = 0; md < 8; md++) begin
                k++;
                b = 32'h0000_0040 + 32'(k) * 32'h0123_4567;
                run_one(b, m, md[0], md[1], md[2], (k % 3) == 0);
            end
        end

        // Reset in the middle of a request.
        base_in = 32'h1000; reg_mask = 16'hFF00; incl_base = 1'b1; up_dir = 1'b1;
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        rst = 1'b1;
        step();
        chk(xfer_valid == 1'b0 && done == 1'b0, "R9 mid-run reset",
            32'({xfer_valid, done}), 32'd0);
        rst = 1'b0;
        step();
        chk(xfer_valid == 1'b0 && done == 1'b0, "R9 stays idle",
            32'({xfer_valid, done}), 32'd0);
        run_one(32'h2000, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule